// File: doc/BRIEF.md
# Receive Block Pool Allocator

This block keeps track of a pool of equally sized receive blocks in external memory for a two-port Ethernet switch. Each block is 1536 bytes and holds exactly one complete frame. The block keeps one status bit per block, marking it either free or in use. A receiving port asks for a block and gets back the index of a free one, or a refusal. In that case the port drops the frame. After a frame has been sent out, its block is handed back by index.

Two straps are captured while reset is held. The first picks the pool mode: one shared pool for both ports, or a fixed quota per port. The second picks the memory size. With the large memory the shared pool has 1008 blocks and each quota is 320 blocks. With the small memory the figures are 308 and 140. In quota mode, port p owns blocks p*Q to (p+1)*Q-1, where Q is the quota. A per-port full flag reports when a port's quota is used up. The flag is only active in quota mode.

Both request inputs use a valid/ready handshake. A request is taken on a rising edge where valid and ready are both high. Ready is high whenever reset is released and never drops because of load, so no request ever waits. The allocation response has no back-pressure: it shows for exactly one cycle and the requester must take it then.

Top module: `rxb_alloc`

## Requirements
- R1: While rst_n is low (synchronous reset), every block becomes free, rsp_valid is 0, buf_full is 0 and rel_err is 0.
- R2: strap_quota (1 = per-port quota, 0 = shared pool) and strap_big (1 = large memory, 0 = small) are captured on each clock edge with rst_n low; changes to them after reset have no effect.
- R3: An allocation request accepted at edge k gives rsp_valid = 1 in the cycle after edge k. With rsp_ok = 1, rsp_idx is the lowest-numbered free block in the eligible range, and that block is marked in use. A cycle with no accepted request gives rsp_valid = 0.
- R4: In shared mode, either port may take any block from 0 to N-1, where N is 1008 (large) or 308 (small).
- R5: In quota mode, a request from port p (alloc_port = p) considers only blocks p*Q to (p+1)*Q-1, where Q is 320 (large) or 140 (small).
- R6: If no eligible block is free, the response has rsp_ok = 0 and rsp_idx = 0, and no block changes state.
- R7: An accepted release of an in-use block that lies inside the active pool (below N in shared mode, below 2*Q in quota mode) marks the block free. The block can then be allocated by a request accepted on a later edge.
- R8: A release of a block that is already free, or that lies outside the active pool, changes no block. It sets rel_err, which stays 1 until reset.
- R9: In quota mode, buf_full[p] is 1 exactly when all Q blocks of port p are in use. In shared mode, buf_full stays 0.
- R10: alloc_ready and rel_ready are 1 whenever rst_n is high and 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_quota | input | 1 | Pool mode strap, captured during reset |
| strap_big | input | 1 | Memory size strap, captured during reset |
| alloc_valid | input | 1 | Allocation request valid |
| alloc_ready | output | 1 | Allocation request ready |
| alloc_port | input | 1 | Requesting port number |
| rsp_valid | output | 1 | Allocation response present |
| rsp_ok | output | 1 | 1 = block granted, 0 = refused |
| rsp_idx | output | 10 | Granted block index |
| rel_valid | input | 1 | Release request valid |
| rel_ready | output | 1 | Release request ready |
| rel_idx | input | 10 | Index of the block being released |
| buf_full | output | 2 | Per-port quota exhausted |
| rel_err | output | 1 | Sticky flag for an invalid release |

## Verification
The assertions check these properties on every cycle:
- each accepted request gets exactly one response, one cycle later;
- a refusal carries index zero;
- a granted index lies in the requester's quota window, or below the pool size in shared mode;
- a port that is flagged full is refused;
- buf_full stays low in shared mode;
- the captured mode holds steady after reset;
- rel_err is sticky.

Only the bench's scenarios can show the following:
- that the index returned is the lowest free block;
- that a freed block becomes available again;
- that a duplicate release leaves the pool unchanged;
- that the full flag rises exactly at quota exhaustion and falls again when a block is released.

The bench checks these against a reference model of the occupancy.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic {
    POOL_SHARED = 1'b0,
    POOL_QUOTA  = 1'b1
  } pool_mode_e;
endpackage

// File: rtl/rxb_low_pick.sv
// Priority pick: returns the lowest set bit of a candidate vector.
module rxb_low_pick #(
  parameter int N     = 1008,
  parameter int IDX_W = 10
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rxb_occ_map.sv
// One status bit per block (1 = in use), with a windowed free-block search.
module rxb_occ_map #(
  parameter int NBLK  = 1008,
  parameter int IDX_W = 10,
  parameter int LIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] win_lo,
  input  logic [LIM_W-1:0] win_hi,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic             clr_busy,
  output logic             find_ok,
  output logic [IDX_W-1:0] find_idx
);
  logic [NBLK-1:0] occ;
  logic [NBLK-1:0] cand;

  for (genvar i = 0; i < NBLK; i++) begin : g_cand
    assign cand[i] = !occ[i] && (LIM_W'(i) >= win_lo) && (LIM_W'(i) < win_hi);
  end

  rxb_low_pick #(.N(NBLK), .IDX_W(IDX_W)) pick_i (
    .cand  (cand),
    .found (find_ok),
    .idx   (find_idx)
  );

  assign clr_busy = (int'(clr_idx) < NBLK) ? occ[clr_idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      if (set_en) occ[set_idx] <= 1'b1;
      if (clr_en) occ[clr_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxb_quota_ctr.sv
// Per-port count of blocks in use, compared to the quota.
module rxb_quota_ctr #(
  parameter int CNT_W = 9,
  parameter int LIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic [LIM_W-1:0] limit,
  output logic             full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign full = (LIM_W'(cnt) == limit);
endmodule

// File: rtl/rxb_alloc.sv
module rxb_alloc
  import rxb_pkg::*;
#(
  parameter int NBLK_BIG    = 1008,
  parameter int NBLK_SMALL  = 308,
  parameter int QUOTA_BIG   = 320,
  parameter int QUOTA_SMALL = 140,
  parameter int NPORT       = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             strap_quota,
  input  logic                             strap_big,
  input  logic                             alloc_valid,
  output logic                             alloc_ready,
  input  logic [$clog2(NPORT)-1:0]         alloc_port,
  output logic                             rsp_valid,
  output logic                             rsp_ok,
  output logic [$clog2(NBLK_BIG)-1:0]      rsp_idx,
  input  logic                             rel_valid,
  output logic                             rel_ready,
  input  logic [$clog2(NBLK_BIG)-1:0]      rel_idx,
  output logic [NPORT-1:0]                 buf_full,
  output logic                             rel_err
);
  localparam int IDX_W = $clog2(NBLK_BIG);
  localparam int LIM_W = IDX_W + 1;
  localparam int CNT_W = $clog2(QUOTA_BIG + 1);

  pool_mode_e       mode_q;
  logic             big_q;
  logic             is_quota;
  logic [LIM_W-1:0] pool_size, quota, win_lo, win_hi, rel_limit;
  logic             acc_alloc, acc_rel, rel_busy, rel_good, grant;
  logic             find_ok;
  logic [IDX_W-1:0] find_idx;
  logic [NPORT-1:0] ctr_full;

  // Straps are captured only while reset is held (R2)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= strap_quota ? POOL_QUOTA : POOL_SHARED;
      big_q  <= strap_big;
    end
  end

  assign is_quota  = (mode_q == POOL_QUOTA);
  assign pool_size = big_q ? LIM_W'(NBLK_BIG) : LIM_W'(NBLK_SMALL);
  assign quota     = big_q ? LIM_W'(QUOTA_BIG) : LIM_W'(QUOTA_SMALL);
  assign win_lo    = is_quota ? LIM_W'(alloc_port) * quota : '0;
  assign win_hi    = is_quota ? win_lo + quota : pool_size;
  assign rel_limit = is_quota ? LIM_W'(NPORT) * quota : pool_size;

  assign alloc_ready = rst_n;
  assign rel_ready   = rst_n;
  assign acc_alloc   = alloc_valid && alloc_ready;
  assign acc_rel     = rel_valid && rel_ready;
  assign rel_good    = acc_rel && (LIM_W'(rel_idx) < rel_limit) && rel_busy;
  assign grant       = acc_alloc && find_ok;

  rxb_occ_map #(.NBLK(NBLK_BIG), .IDX_W(IDX_W), .LIM_W(LIM_W)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .set_en   (grant),
    .set_idx  (find_idx),
    .clr_en   (rel_good),
    .clr_idx  (rel_idx),
    .clr_busy (rel_busy),
    .find_ok  (find_ok),
    .find_idx (find_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_idx   <= '0;
      rel_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_alloc;
      rsp_ok    <= grant;
      rsp_idx   <= grant ? find_idx : '0;
      if (acc_rel && !rel_good) rel_err <= 1'b1;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [LIM_W-1:0] p_lo;
    logic             p_inc, p_dec;
    assign p_lo  = LIM_W'(p) * quota;
    assign p_inc = grant && is_quota && (int'(alloc_port) == p);
    assign p_dec = rel_good && is_quota &&
                   (LIM_W'(rel_idx) >= p_lo) && (LIM_W'(rel_idx) < p_lo + quota);
    rxb_quota_ctr #(.CNT_W(CNT_W), .LIM_W(LIM_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (p_inc),
      .dec   (p_dec),
      .limit (quota),
      .full  (ctr_full[p])
    );
    assign buf_full[p] = is_quota && ctr_full[p];
  end
endmodule

// File: rtl/rxb_alloc_chk.sv
module rxb_alloc_chk #(
  parameter int NPORT = 2,
  parameter int IDX_W = 10,
  parameter int LIM_W = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alloc_valid,
  input logic                     alloc_ready,
  input logic [$clog2(NPORT)-1:0] alloc_port,
  input logic                     rel_ready,
  input logic                     rsp_valid,
  input logic                     rsp_ok,
  input logic [IDX_W-1:0]         rsp_idx,
  input logic [NPORT-1:0]         buf_full,
  input logic                     rel_err,
  input logic                     is_quota,
  input logic [LIM_W-1:0]         quota,
  input logic [LIM_W-1:0]         pool_size
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> rsp_valid); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_valid && alloc_ready) |=> !rsp_valid); // R3
  AST_FAIL_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_idx == '0)); // R6
  AST_SHARED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && !is_quota) |-> (int'(rsp_idx) < int'(pool_size))); // R4
  AST_QUOTA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && is_quota) |->
      ((int'(rsp_idx) >= int'($past(alloc_port)) * int'(quota)) &&
       (int'(rsp_idx) <  (int'($past(alloc_port)) + 1) * int'(quota)))); // R5
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && is_quota && buf_full[alloc_port]) |=> (rsp_valid && !rsp_ok)); // R9
  AST_NO_FULL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    !is_quota |-> (buf_full == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(is_quota)); // R2
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (alloc_ready && rel_ready)); // R10
endmodule

bind rxb_alloc rxb_alloc_chk #(
  .NPORT (NPORT),
  .IDX_W ($clog2(NBLK_BIG)),
  .LIM_W ($clog2(NBLK_BIG) + 1)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_port  (alloc_port),
  .rel_ready   (rel_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ok      (rsp_ok),
  .rsp_idx     (rsp_idx),
  .buf_full    (buf_full),
  .rel_err     (rel_err),
  .is_quota    (is_quota),
  .quota       (quota),
  .pool_size   (pool_size)
);

// File: tb/rxb_alloc_tb_top.sv
`timescale 1ns/1ps
module rxb_alloc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_quota = 1'b0, strap_big = 1'b1;
  logic       alloc_valid = 1'b0, alloc_port = 1'b0;
  logic       rel_valid = 1'b0;
  logic [9:0] rel_idx = '0;
  logic       alloc_ready, rel_ready, rsp_valid, rsp_ok, rel_err;
  logic [9:0] rsp_idx;
  logic [1:0] buf_full;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  bit occ_m [0:1023];
  int cnt_m [0:1];
  bit quota_m, big_m, err_m;

  always #2.5 clk = ~clk;

  rxb_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .strap_quota(strap_quota), .strap_big(strap_big),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_port(alloc_port),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_idx(rsp_idx),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_idx(rel_idx),
    .buf_full(buf_full), .rel_err(rel_err)
  );

  function automatic int qsize();
    return big_m ? 320 : 140;
  endfunction
  function automatic int psize();
    return big_m ? 1008 : 308;
  endfunction
  function automatic int rel_lim();
    return quota_m ? 2 * qsize() : psize();
  endfunction
  function automatic int exp_find(int port);
    int lo = quota_m ? port * qsize() : 0;
    int hi = quota_m ? lo + qsize() : psize();
    for (int i = lo; i < hi; i++) if (!occ_m[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(bit q, bit b);
    rst_n = 1'b0; alloc_valid = 1'b0; rel_valid = 1'b0;
    strap_quota = q; strap_big = b;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ready low in reset", int'(alloc_ready) + int'(rel_ready), 0);
    chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
    chk("R1 buf_full in reset", int'(buf_full), 0);
    chk("R1 rel_err in reset", int'(rel_err), 0);
    for (int i = 0; i < 1024; i++) occ_m[i] = 0;
    cnt_m[0] = 0; cnt_m[1] = 0; err_m = 0; quota_m = q; big_m = b;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 ready high", int'(alloc_ready) + int'(rel_ready), 2);
  endtask

  // one cycle: optional allocation and optional release, then full check
  task automatic step(bit a_en, bit port, bit r_en, int ridx);
    int  e_idx;
    bit  good;
    e_idx = a_en ? exp_find(port) : -1;
    good  = r_en && (ridx < rel_lim()) && occ_m[ridx];
    alloc_valid = a_en; alloc_port = port;
    rel_valid = r_en; rel_idx = 10'(ridx);
    @(posedge clk); #1;
    alloc_valid = 1'b0; rel_valid = 1'b0;
    if (good) begin
      occ_m[ridx] = 0;
      if (quota_m) cnt_m[ridx / qsize()]--;
    end
    if (r_en && !good) err_m = 1;
    if (a_en && e_idx >= 0) begin
      occ_m[e_idx] = 1;
      if (quota_m) cnt_m[port]++;
    end
    chk("R3 rsp_valid", int'(rsp_valid), int'(a_en));
    if (a_en) begin
      chk("R6 rsp_ok", int'(rsp_ok), int'(e_idx >= 0));
      chk("R3 rsp_idx", int'(rsp_idx), (e_idx >= 0) ? e_idx : 0);
    end
    chk("R8 rel_err", int'(rel_err), int'(err_m));
    for (int p = 0; p < 2; p++)
      chk("R9 buf_full", int'(buf_full[p]), int'(quota_m && cnt_m[p] == qsize()));
  endtask

  task automatic rand_phase(int n);
    for (int k = 0; k < n; k++) begin
      bit a = ($urandom % 10) < 6;
      bit p = $urandom % 2;
      bit r = ($urandom % 2) == 1;
      int idx = $urandom % 1024;
      if (r && ($urandom % 10) < 8) begin
        int st = $urandom % rel_lim();
        for (int j = 0; j < rel_lim(); j++) begin
          int c = (st + j) % rel_lim();
          if (occ_m[c]) begin idx = c; break; end
        end
      end
      step(a, p, r, idx);
    end
  endtask

  initial begin
    void'($urandom(32'd7351));
    // shared pool, large memory
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 1008; i++) step(1'b1, i[0], 1'b0, 0);  // R4 fills 0..1007
    step(1'b1, 1'b0, 1'b0, 0);                                 // R6 refused
    chk("R4 pool exhausted", int'(rsp_ok), 0);
    step(1'b0, 1'b0, 1'b1, 500);                               // R7 free block 500
    step(1'b0, 1'b0, 1'b1, 500);                               // R8 duplicate release
    step(1'b1, 1'b1, 1'b0, 0);                                 // R7 re-grant 500
    chk("R7 freed block reused", int'(rsp_idx), 500);
    step(1'b1, 1'b0, 1'b0, 0);                                 // R8 pool unchanged: refusal
    step(1'b0, 1'b0, 1'b1, 1010);                              // R8 out of pool
    // quota mode, small memory; straps flipped after reset
    do_reset(1'b1, 1'b0);
    chk("R1 error cleared", int'(rel_err), 0);
    strap_quota = 1'b0; strap_big = 1'b1;                      // R2 ignored now
    for (int i = 0; i < 141; i++) step(1'b1, 1'b0, 1'b0, 0);   // R5 0..139 then refusal
    chk("R9 port0 full", int'(buf_full[0]), 1);
    chk("R2 quota kept after strap change", int'(rsp_ok), 0);
    step(1'b1, 1'b1, 1'b0, 0);
    chk("R5 port1 window start", int'(rsp_idx), 140);
    step(1'b0, 1'b0, 1'b1, 5);
    chk("R9 full drops on release", int'(buf_full[0]), 0);
    step(1'b1, 1'b0, 1'b1, 300);                               // R8 beyond 2*Q, R7 reuse
    chk("R7 port0 reuse", int'(rsp_idx), 5);
    rand_phase(4000);
    // quota mode, large memory
    do_reset(1'b1, 1'b1);
    rand_phase(4000);
    // shared pool, small memory
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 309; i++) step(1'b1, $urandom % 2, 1'b0, 0);
    chk("R4 small pool refusal", int'(rsp_ok), 0);
    rand_phase(4000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule